// File: doc/BRIEF.md
# Windowed Call Entry Return Controller

This controller keeps the window state that a register-windowed processor uses for subroutine calls. The physical register file is split into groups of four registers. A base pointer selects which group is seen as logical registers 0 to 3, and a live mask holds one bit per group. The register storage itself is outside the block. The controller produces the register-file write that each operation needs, and for a return it also produces the control-transfer target.

There are three operations. A call picks an increment of 1, 2 or 3 groups, which hides 4, 8 or 12 low registers from the callee. The call does not rotate the window. It keeps the increment in two places: a 2-bit status field, and the top two bits of the return address it writes. An entry rotates the window forward by the status increment and marks the new frame live. In the same step it writes the new stack pointer, which is the caller's stack pointer minus a frame size. A return reads the increment back from the top bits of the return address, clears the live bit of the frame it leaves, and rotates the base back.

Only one operation may be requested per cycle. Any invalid request raises an error flag and changes nothing. All results are registered and appear one clock after the request. The group count must be a power of two, so that base arithmetic wraps modulo the count.

Top module: `wincall_ctrl`

## Requirements
- R1: Synchronous active-low reset sets the window base to 0, the live mask to 1 (only group 0 live), the status increment to 0, and rf_we, ret_valid and err_o to 0.
- R2: A valid call (call_req alone, call_inc nonzero) sets stat_inc to call_inc on the next clock. It writes rf_wdata = {call_inc, pc_in[XLEN-3:0]} to physical register rf_waddr = ((win_base + call_inc) mod NGRP)*4. It leaves win_base and win_start unchanged.
- R3: An entry (ent_req alone) sets win_base to (win_base + stat_inc) mod NGRP on the next clock and sets the live-mask bit of that new base.
- R4: In the same cycle as R3, an entry writes rf_wdata = sp_in - frame_sz (frame_sz zero-extended) to physical register rf_waddr = new_base*4 + 1.
- R5: A return (ret_req alone) takes its increment from ra_in[XLEN-1:XLEN-2]. On the next clock it clears the live-mask bit of the current base and sets win_base to (win_base - increment) mod NGRP. It does not write the register file.
- R6: A return raises ret_valid for one cycle with ret_target = {pc_in[XLEN-1:XLEN-2], ra_in[XLEN-3:0]}.
- R7: Two or more requests in one cycle, or a call with call_inc = 0, raise err_o for the next cycle. Such a cycle gives no write and no ret_valid, and leaves win_base, win_start and stat_inc unchanged.
- R8: Base arithmetic wraps. With NGRP = 16, an entry of 3 groups from base 15 gives base 2, and a return of 3 groups from base 2 gives base 15.
- R9: A cycle with no request gives rf_we = 0, ret_valid = 0 and err_o = 0, and holds win_base, win_start and stat_inc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Call request |
| call_inc | input | 2 | Call increment in groups (1..3) |
| ent_req | input | 1 | Entry request |
| ret_req | input | 1 | Return request |
| pc_in | input | XLEN | Return PC for a call; current PC for a return |
| sp_in | input | XLEN | Caller's stack pointer (old logical register 1) |
| frame_sz | input | FSZ_W | Frame size subtracted at entry |
| ra_in | input | XLEN | Return address (logical register 0) at return |
| win_base | output | log2(NGRP) | Current window base group |
| win_start | output | NGRP | Live-frame mask, one bit per group |
| stat_inc | output | 2 | Recorded call increment |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | log2(4*NGRP) | Physical register write index |
| rf_wdata | output | XLEN | Register-file write data |
| ret_valid | output | 1 | Return target valid |
| ret_target | output | XLEN | Return target address |
| err_o | output | 1 | Invalid request flagged |

## Verification
Every result is due exactly one rising edge after the request: state, write port, return target and error flag alike. The bench drives each request on a falling edge. It samples all outputs on the next falling edge, after that single rising edge, and drives the following request at the same instant. The expected write address and data for each step come from the expected base before that step and the bench's own record of the increment. The wrap and error cases are directed tests after the table walk.

// File: rtl/wincall_pkg.sv
// Shared types of the windowed call controller.
// Assumes nothing beyond a two-bit operation code.
package wincall_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CALL = 2'd1,
        OP_ENT  = 2'd2,
        OP_RET  = 2'd3
    } wc_op_e;
endpackage

// File: rtl/wincall_decode.sv
// Request decoder: turns the three request lines into one operation code.
// Flags a conflict when more than one request is raised, or when a call
// has a zero increment. A flagged cycle decodes to no operation.
module wincall_decode
    import wincall_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       call_req,
    input  logic [1:0] call_inc,
    input  logic       ent_req,
    input  logic       ret_req,
    output wc_op_e     op,
    output logic       bad
);
    logic [1:0] n_req;

    // Count the raised requests and decide validity.
    always_comb begin
        n_req = 2'(call_req) + 2'(ent_req) + 2'(ret_req);
        bad   = (n_req > 2'd1) || (call_req && call_inc == 2'd0);
        if (bad)           op = OP_NONE;
        else if (call_req) op = OP_CALL;
        else if (ent_req)  op = OP_ENT;
        else if (ret_req)  op = OP_RET;
        else               op = OP_NONE;
    end

    // R7: a decoded operation comes from exactly one request line
    p_single_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_NONE) |-> ($countones({call_req, ent_req, ret_req}) == 1));
endmodule

// File: rtl/wincall_window.sv
// Window state: base pointer, live mask and recorded call increment.
// Assumes NGRP is a power of two, so base arithmetic wraps by truncation.
// Also gives the target group of a call or entry for the write port.
module wincall_window
    import wincall_pkg::*;
#(
    parameter int NGRP = 16,
    localparam int BW  = $clog2(NGRP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  wc_op_e          op,
    input  logic [1:0]      call_inc,
    input  logic [1:0]      ret_inc,
    output logic [BW-1:0]   win_base,
    output logic [NGRP-1:0] win_start,
    output logic [1:0]      stat_inc,
    output logic [BW-1:0]   tgt_base
);
    // Target group: base plus the call increment, or plus the recorded one.
    always_comb begin
        if (op == OP_CALL) tgt_base = win_base + BW'(call_inc);
        else               tgt_base = win_base + BW'(stat_inc);
    end

    // Advance, retreat or hold the window state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base  <= '0;
            win_start <= NGRP'(1);
            stat_inc  <= 2'd0;
        end else begin
            case (op)
                OP_CALL: stat_inc <= call_inc;
                OP_ENT: begin
                    win_base            <= tgt_base;
                    win_start[tgt_base] <= 1'b1;
                end
                OP_RET: begin
                    win_base            <= win_base - BW'(ret_inc);
                    win_start[win_base] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R3: entry moves the base forward by the recorded increment
    p_entry_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ENT) |=> (win_base == BW'($past(win_base) + BW'($past(stat_inc)))));
    // R3: the new frame is live after entry
    p_entry_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ENT) |=> win_start[win_base]);
    // R5: the frame being left is no longer live after return
    p_ret_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RET) |=> !win_start[$past(win_base)]);
    // R2: a call leaves base and mask alone
    p_call_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL) |=> ($stable(win_base) && $stable(win_start)));
    // R9: no operation holds all window state
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |=> ($stable(win_base) && $stable(win_start) && $stable(stat_inc)));
endmodule

// File: rtl/wincall_wport.sv
// Write-port and return-target former. It registers the register-file
// write for a call (return address into the callee's register 0) or an
// entry (new stack pointer into the new register 1), and the target of
// a return. It also registers the error flag.
module wincall_wport
    import wincall_pkg::*;
#(
    parameter int NGRP  = 16,
    parameter int XLEN  = 32,
    parameter int FSZ_W = 12,
    localparam int BW   = $clog2(NGRP),
    localparam int RW   = BW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wc_op_e           op,
    input  logic             bad,
    input  logic [BW-1:0]    tgt_base,
    input  logic [1:0]       call_inc,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [FSZ_W-1:0] frame_sz,
    input  logic [XLEN-1:0]  ra_in,
    output logic             rf_we,
    output logic [RW-1:0]    rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             ret_valid,
    output logic [XLEN-1:0]  ret_target,
    output logic             err_o
);
    // Register the write, return target and error for the decoded operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we      <= 1'b0;
            rf_waddr   <= '0;
            rf_wdata   <= '0;
            ret_valid  <= 1'b0;
            ret_target <= '0;
            err_o      <= 1'b0;
        end else begin
            rf_we     <= (op == OP_CALL) || (op == OP_ENT);
            ret_valid <= (op == OP_RET);
            err_o     <= bad;
            case (op)
                OP_CALL: begin
                    rf_waddr <= {tgt_base, 2'd0};
                    rf_wdata <= {call_inc, pc_in[XLEN-3:0]};
                end
                OP_ENT: begin
                    rf_waddr <= {tgt_base, 2'd1};
                    rf_wdata <= sp_in - XLEN'(frame_sz);
                end
                OP_RET: ret_target <= {pc_in[XLEN-1:XLEN-2], ra_in[XLEN-3:0]};
                default: ;
            endcase
        end
    end

    // R2: a call writes the increment into the return address top bits
    p_call_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL) |=> (rf_we && rf_wdata[XLEN-1:XLEN-2] == $past(call_inc)));
    // R4: entry writes logical register 1 of the new frame
    p_entry_reg1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ENT) |=> (rf_we && rf_waddr[1:0] == 2'd1));
    // R6: a return never writes the register file
    p_ret_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !rf_we);
endmodule

// File: rtl/wincall_ctrl.sv
// Top of the windowed call/entry/return controller. It joins the request
// decoder, the window state and the write-port former. All outputs are
// registered and follow a request by one clock. Assumes NGRP is a power
// of two and at least 4.
module wincall_ctrl
    import wincall_pkg::*;
#(
    parameter int NGRP  = 16,
    parameter int XLEN  = 32,
    parameter int FSZ_W = 12,
    localparam int BW   = $clog2(NGRP),
    localparam int RW   = BW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_req,
    input  logic [1:0]       call_inc,
    input  logic             ent_req,
    input  logic             ret_req,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [FSZ_W-1:0] frame_sz,
    input  logic [XLEN-1:0]  ra_in,
    output logic [BW-1:0]    win_base,
    output logic [NGRP-1:0]  win_start,
    output logic [1:0]       stat_inc,
    output logic             rf_we,
    output logic [RW-1:0]    rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             ret_valid,
    output logic [XLEN-1:0]  ret_target,
    output logic             err_o
);
    wc_op_e        op;
    logic          bad;
    logic [BW-1:0] tgt_base;
    logic [1:0]    ret_inc;

    // Return increment lives in the top two bits of the return address.
    always_comb ret_inc = ra_in[XLEN-1:XLEN-2];

    wincall_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_req (call_req),
        .call_inc (call_inc),
        .ent_req  (ent_req),
        .ret_req  (ret_req),
        .op       (op),
        .bad      (bad)
    );

    wincall_window #(.NGRP(NGRP)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .call_inc  (call_inc),
        .ret_inc   (ret_inc),
        .win_base  (win_base),
        .win_start (win_start),
        .stat_inc  (stat_inc),
        .tgt_base  (tgt_base)
    );

    wincall_wport #(.NGRP(NGRP), .XLEN(XLEN), .FSZ_W(FSZ_W)) u_wport (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .bad        (bad),
        .tgt_base   (tgt_base),
        .call_inc   (call_inc),
        .pc_in      (pc_in),
        .sp_in      (sp_in),
        .frame_sz   (frame_sz),
        .ra_in      (ra_in),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .ret_valid  (ret_valid),
        .ret_target (ret_target),
        .err_o      (err_o)
    );

    // R7: a flagged cycle produces neither a write nor a return
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!rf_we && !ret_valid));
    // R7: a rejected request leaves the window state unchanged
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> ($stable(win_base) && $stable(win_start) && $stable(stat_inc)));
endmodule

// File: tb/wincall_ctrl_bench.sv
// Bench for the windowed call controller: a table walk of call/entry/return
// steps, then directed reset, wrap and conflict tests.
module wincall_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NGRP = 16;
    localparam int XLEN = 32;
    localparam int FSZ_W = 12;
    localparam int NVEC = 10;

    // {op[1:0], inc[1:0], exp_base[3:0], exp_mask[15:0]}; op 0 idle,1 call,2 entry,3 return
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd1, 2'd1, 4'd0, 16'h0001},
        {2'd2, 2'd0, 4'd1, 16'h0003},
        {2'd1, 2'd2, 4'd1, 16'h0003},
        {2'd2, 2'd0, 4'd3, 16'h000B},
        {2'd1, 2'd3, 4'd3, 16'h000B},
        {2'd2, 2'd0, 4'd6, 16'h004B},
        {2'd3, 2'd3, 4'd3, 16'h000B},
        {2'd3, 2'd2, 4'd1, 16'h0003},
        {2'd3, 2'd1, 4'd0, 16'h0001},
        {2'd0, 2'd0, 4'd0, 16'h0001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic call_req = 1'b0, ent_req = 1'b0, ret_req = 1'b0;
    logic [1:0] call_inc = 2'd0;
    logic [XLEN-1:0] pc_in = '0, sp_in = '0, ra_in = '0;
    logic [FSZ_W-1:0] frame_sz = '0;
    logic [3:0] win_base;
    logic [NGRP-1:0] win_start;
    logic [1:0] stat_inc;
    logic rf_we, ret_valid, err_o;
    logic [5:0] rf_waddr;
    logic [XLEN-1:0] rf_wdata, ret_target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wincall_ctrl #(.NGRP(NGRP), .XLEN(XLEN), .FSZ_W(FSZ_W)) u_wincall_ctrl (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_inc(call_inc),
        .ent_req(ent_req), .ret_req(ret_req), .pc_in(pc_in), .sp_in(sp_in),
        .frame_sz(frame_sz), .ra_in(ra_in), .win_base(win_base),
        .win_start(win_start), .stat_inc(stat_inc), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .ret_valid(ret_valid),
        .ret_target(ret_target), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; results are due at the next one.
    task automatic step(input logic c, input logic e, input logic r, input logic [1:0] inc);
        call_req = c; ent_req = e; ret_req = r; call_inc = inc;
        @(negedge clk);
        call_req = 1'b0; ent_req = 1'b0; ret_req = 1'b0; call_inc = 2'd0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [3:0] pbase;
        logic [1:0] rec;
        @(negedge clk);
        do_reset();
        chk("R1 base", 32'(win_base), 32'd0);
        chk("R1 mask", 32'(win_start), 32'h0001);
        chk("R1 stat", 32'(stat_inc), 32'd0);
        chk("R1 quiet", {29'd0, rf_we, ret_valid, err_o}, 32'd0);

        pbase = 4'd0; rec = 2'd0;
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op, inc;
            logic [3:0] eb;
            logic [15:0] em;
            {op, inc, eb, em} = VEC[i];
            pc_in = 32'h4000_0100 + 32'(i * 16);
            sp_in = 32'h0000_8000 - 32'(i * 64);
            frame_sz = 12'(32 + i * 16);
            ra_in = {inc, 30'h0123_4560 + 30'(i)};
            step(op == 2'd1, op == 2'd2, op == 2'd3, inc);
            chk("R3 R5 base", 32'(win_base), 32'(eb));
            chk("R3 R5 mask", 32'(win_start), 32'(em));
            case (op)
                2'd1: begin
                    rec = inc;
                    chk("R2 stat", 32'(stat_inc), 32'(inc));
                    chk("R2 we", 32'(rf_we), 32'd1);
                    chk("R2 addr", 32'(rf_waddr), 32'({4'(pbase + 4'(inc)), 2'd0}));
                    chk("R2 data", rf_wdata, {inc, pc_in[29:0]});
                end
                2'd2: begin
                    chk("R4 we", 32'(rf_we), 32'd1);
                    chk("R4 addr", 32'(rf_waddr), 32'({4'(pbase + 4'(rec)), 2'd1}));
                    chk("R4 data", rf_wdata, sp_in - 32'(frame_sz));
                end
                2'd3: begin
                    chk("R6 valid", 32'(ret_valid), 32'd1);
                    chk("R6 target", ret_target, {pc_in[31:30], ra_in[29:0]});
                    chk("R5 nowrite", 32'(rf_we), 32'd0);
                end
                default: begin
                    chk("R9 quiet", {29'd0, rf_we, ret_valid, err_o}, 32'd0);
                    chk("R9 stat", 32'(stat_inc), 32'(rec));
                end
            endcase
            pbase = eb;
        end

        // R8: walk to base 15, then enter by 3 and return by 3 across the wrap.
        do_reset();
        for (int k = 0; k < 5; k++) begin
            step(1'b1, 1'b0, 1'b0, 2'd3);
            step(1'b0, 1'b1, 1'b0, 2'd0);
        end
        chk("R8 base15", 32'(win_base), 32'd15);
        step(1'b1, 1'b0, 1'b0, 2'd3);
        sp_in = 32'h0000_1000; frame_sz = 12'd48;
        step(1'b0, 1'b1, 1'b0, 2'd0);
        chk("R8 wrap up base", 32'(win_base), 32'd2);
        chk("R8 wrap up mask", 32'(win_start), 32'h924D);
        chk("R8 wrap up addr", 32'(rf_waddr), 32'd9);
        chk("R4 wrap data", rf_wdata, 32'h0000_0FD0);
        ra_in = {2'd3, 30'h0000_0040};
        step(1'b0, 1'b0, 1'b1, 2'd0);
        chk("R8 wrap down base", 32'(win_base), 32'd15);
        chk("R8 wrap down mask", 32'(win_start), 32'h9249);

        // R7: conflicting requests and a zero-increment call.
        step(1'b1, 1'b1, 1'b0, 2'd1);
        chk("R7 err", 32'(err_o), 32'd1);
        chk("R7 quiet", {30'd0, rf_we, ret_valid}, 32'd0);
        chk("R7 base", 32'(win_base), 32'd15);
        chk("R7 stat", 32'(stat_inc), 32'd3);
        step(1'b0, 1'b1, 1'b1, 2'd0);
        chk("R7 err2", 32'(err_o), 32'd1);
        chk("R7 mask", 32'(win_start), 32'h9249);
        step(1'b1, 1'b0, 1'b0, 2'd0);
        chk("R7 zero inc err", 32'(err_o), 32'd1);
        chk("R7 zero inc nowrite", 32'(rf_we), 32'd0);
        chk("R7 zero inc stat", 32'(stat_inc), 32'd3);
        step(1'b0, 1'b0, 1'b0, 2'd0);
        chk("R9 err clears", 32'(err_o), 32'd0);

        // R1: reset in mid-run restores the initial state.
        do_reset();
        chk("R1 base again", 32'(win_base), 32'd0);
        chk("R1 mask again", 32'(win_start), 32'h0001);
        chk("R1 stat again", 32'(stat_inc), 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule